// File: doc/BRIEF.md
# Delay-line sample width encoder

This block turns the per-clock snapshot of a tapped delay line into one linearised sample code. Each clock, a comparator output is caught along two interleaved delay chains. The comparator compares the input voltage against a reference ramp that repeats once per sample period. The block merges the two chains into one snapshot at twice the tap count. It counts every high tap across the merged snapshot to get a width code. It then maps that width through a table that software loads, which gives the final code. The table is needed because the reference ramp is exponential, so the raw width is only roughly proportional to the input voltage.

The width is a count of set taps, not the position of one edge. When the sampling phase is aligned, the high region can wrap around the period and show up as two separate groups, one at each end of the line. One code with a valid strobe comes out per accepted snapshot, and a full snapshot can be accepted on every clock. The table holds one entry for each possible width, from zero to the merged tap count. Its contents are worked out offline from a slow calibration sweep: one output step is the calibrated voltage span divided by the width span seen across it.

Top module: `dl_width_encoder`

## Requirements
- R1: While `rst_n` is low, `code_valid` is 0 and `code` is 0.
- R2: The width of a snapshot is the total number of 1 bits across `chain_a` and `chain_b`. The code is the table entry at that width, and the code is the only thing produced.
- R3: A snapshot whose high taps form two separate groups at the low and high ends of the chains gives a width equal to the sum of both groups.
- R4: An all-zero snapshot looks up entry 0, and an all-one snapshot looks up entry 2×TAPS_PER_CHAIN (entry 256 by default).
- R5: For a snapshot presented with `snap_valid` high at rising edge t, `code_valid` is high with its code after rising edge t+3 (4 edges of latency). `code_valid` goes high exactly once per accepted snapshot, including back-to-back snapshots on every clock.
- R6: While `snap_valid` is low, the chain inputs are ignored, `code_valid` goes low and `code` holds its last value.
- R7: A write with `lut_we` high and `lut_addr` ≤ 2×TAPS_PER_CHAIN stores `lut_wdata` at that address at the rising edge. Later lookups of that width return the new value.
- R8: A write with `lut_addr` > 2×TAPS_PER_CHAIN (257 to 511 by default) changes no table entry.
- R9: When a write and a lookup of the same entry fall on the same rising edge, the lookup returns the entry's previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| snap_valid | input | 1 | Chain snapshot present this cycle |
| chain_a | input | TAPS_PER_CHAIN | Taps of the first chain; merged to the even positions |
| chain_b | input | TAPS_PER_CHAIN | Taps of the second chain; merged to the odd positions |
| lut_we | input | 1 | Table write enable |
| lut_addr | input | clog2(2×TAPS_PER_CHAIN+1) | Table write address (the width code) |
| lut_wdata | input | CODE_W | Table write data |
| code_valid | output | 1 | Strobe, one per accepted snapshot |
| code | output | CODE_W | Linearised sample code |

## Verification
A table write and a lookup can land on the same entry at the same rising edge. The bench provokes this by presenting a snapshot of a known width and then, exactly three cycles later, writing new data to that width's table address. The first code must carry the old entry, and a later snapshot of the same width must carry the new data. Out-of-range writes are mixed in as well, at addresses whose low bits alias valid entries. The bench judges them by looking up those aliased entries and the top entry afterwards.

// File: rtl/dlw_pkg.sv
package dlw_pkg;
  localparam int unsigned DLW_TAPS_DEFAULT  = 128;
  localparam int unsigned DLW_GROUP_DEFAULT = 16;
  localparam int unsigned DLW_CODE_W        = 12;
endpackage

// File: rtl/dlw_merge.sv
module dlw_merge #(
  parameter int unsigned TAPS = 128
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [TAPS-1:0]     chain_a,
  input  logic [TAPS-1:0]     chain_b,
  output logic                valid_q,
  output logic [2*TAPS-1:0]   snap_q
);
  logic [2*TAPS-1:0] snap_d;

  // interleave: even positions from chain a, odd from chain b
  always_comb begin
    for (int i = 0; i < int'(TAPS); i++) begin
      snap_d[2*i]   = chain_a[i];
      snap_d[2*i+1] = chain_b[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      snap_q  <= '0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) snap_q <= snap_d;
    end
  end
endmodule

// File: rtl/dlw_popcount.sv
module dlw_popcount #(
  parameter int unsigned BITS  = 256,
  parameter int unsigned GROUP = 16,
  localparam int unsigned NG   = BITS / GROUP,
  localparam int unsigned PW   = $clog2(GROUP + 1),
  localparam int unsigned CW   = $clog2(BITS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [BITS-1:0] bits_in,
  output logic            valid_q,
  output logic [CW-1:0]   count_q
);
  function automatic logic [PW-1:0] count_group(input logic [GROUP-1:0] v);
    logic [PW-1:0] c;
    c = '0;
    for (int j = 0; j < int'(GROUP); j++) c = c + PW'(v[j]);
    return c;
  endfunction

  logic [PW-1:0] part_d [NG];
  logic [PW-1:0] part_q [NG];
  logic          part_valid_q;
  logic [CW-1:0] sum_d;

  for (genvar g = 0; g < int'(NG); g++) begin : g_group
    assign part_d[g] = count_group(bits_in[g*GROUP +: GROUP]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        part_q[g] <= '0;
      else if (in_valid) part_q[g] <= part_d[g];
    end
  end

  always_comb begin
    sum_d = '0;
    for (int g = 0; g < int'(NG); g++) sum_d = sum_d + CW'(part_q[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      part_valid_q <= 1'b0;
      valid_q      <= 1'b0;
      count_q      <= '0;
    end else begin
      part_valid_q <= in_valid;
      valid_q      <= part_valid_q;
      if (part_valid_q) count_q <= sum_d;
    end
  end
endmodule

// File: rtl/dlw_lut.sv
module dlw_lut #(
  parameter int unsigned AW    = 9,
  parameter int unsigned DEPTH = 257,
  parameter int unsigned DW    = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_valid_q,
  output logic [DW-1:0] rd_data_q
);
  logic [DW-1:0] mem [DEPTH];
  logic          wr_ok;

  assign wr_ok = wr_en && (wr_addr < AW'(DEPTH));

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_addr] <= wr_data;
  end

  // registered read; sees the contents from before a same-edge write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= rd_en;
      if (rd_en) rd_data_q <= mem[rd_addr];
    end
  end
endmodule

// File: rtl/dl_width_encoder.sv
module dl_width_encoder #(
  parameter int unsigned TAPS_PER_CHAIN = dlw_pkg::DLW_TAPS_DEFAULT,
  parameter int unsigned GROUP          = dlw_pkg::DLW_GROUP_DEFAULT,
  parameter int unsigned CODE_W         = dlw_pkg::DLW_CODE_W,
  localparam int unsigned MERGED        = 2 * TAPS_PER_CHAIN,
  localparam int unsigned WIDTH_W       = $clog2(MERGED + 1),
  localparam int unsigned LUT_DEPTH     = MERGED + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      snap_valid,
  input  logic [TAPS_PER_CHAIN-1:0] chain_a,
  input  logic [TAPS_PER_CHAIN-1:0] chain_b,
  input  logic                      lut_we,
  input  logic [WIDTH_W-1:0]        lut_addr,
  input  logic [CODE_W-1:0]         lut_wdata,
  output logic                      code_valid,
  output logic [CODE_W-1:0]         code
);
  logic               merged_valid;
  logic [MERGED-1:0]  merged_snap;
  logic               width_valid;
  logic [WIDTH_W-1:0] width_q;

  dlw_merge #(.TAPS(TAPS_PER_CHAIN)) u_merge (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (snap_valid),
    .chain_a  (chain_a),
    .chain_b  (chain_b),
    .valid_q  (merged_valid),
    .snap_q   (merged_snap)
  );

  dlw_popcount #(.BITS(MERGED), .GROUP(GROUP)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (merged_valid),
    .bits_in  (merged_snap),
    .valid_q  (width_valid),
    .count_q  (width_q)
  );

  dlw_lut #(.AW(WIDTH_W), .DEPTH(LUT_DEPTH), .DW(CODE_W)) u_lut (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (lut_we),
    .wr_addr    (lut_addr),
    .wr_data    (lut_wdata),
    .rd_en      (width_valid),
    .rd_addr    (width_q),
    .rd_valid_q (code_valid),
    .rd_data_q  (code)
  );
endmodule

// File: rtl/dlw_checker.sv
module dlw_checker #(
  parameter int unsigned MERGED  = 256,
  parameter int unsigned WIDTH_W = 9,
  parameter int unsigned CODE_W  = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               snap_valid,
  input logic               code_valid,
  input logic [CODE_W-1:0]  code,
  input logic [WIDTH_W-1:0] width_q
);
  logic [2:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                since_rst <= '0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_idle: assert (code_valid == 1'b0 && code == '0)
        else $error("R1: output active during reset");
    end
  end

  a_r5_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 3'd4) |-> (code_valid == $past(snap_valid, 4)))
    else $error("R5: strobe not four edges after snapshot");

  a_r6_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 3'd1 && !code_valid) |-> $stable(code))
    else $error("R6: code changed without strobe");

  a_r4_width_bound: assert property (@(posedge clk) disable iff (!rst_n)
    width_q <= WIDTH_W'(MERGED))
    else $error("R4: width beyond merged tap count");
endmodule

bind dl_width_encoder dlw_checker #(
  .MERGED(MERGED), .WIDTH_W(WIDTH_W), .CODE_W(CODE_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .snap_valid (snap_valid),
  .code_valid (code_valid),
  .code       (code),
  .width_q    (width_q)
);

// File: tb/dl_width_encoder_bench.sv
module dl_width_encoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TAPS   = 128;
  localparam int MERGED = 2 * TAPS;
  localparam int DEPTH  = MERGED + 1;
  localparam int WW     = 9;
  localparam int CW     = 12;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            snap_valid = 1'b0;
  logic [TAPS-1:0] chain_a = '0;
  logic [TAPS-1:0] chain_b = '0;
  logic            lut_we = 1'b0;
  logic [WW-1:0]   lut_addr = '0;
  logic [CW-1:0]   lut_wdata = '0;
  logic            code_valid;
  logic [CW-1:0]   code;

  dl_width_encoder u_dl_width_encoder (
    .clk(clk), .rst_n(rst_n), .snap_valid(snap_valid),
    .chain_a(chain_a), .chain_b(chain_b),
    .lut_we(lut_we), .lut_addr(lut_addr), .lut_wdata(lut_wdata),
    .code_valid(code_valid), .code(code)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural expectation
  logic [CW-1:0] tbl_m [DEPTH];
  bit            v1, v2, v3, cv_m;
  logic [WW-1:0] w1, w2, w3;
  logic [CW-1:0] code_m;

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 1'b0;
  string cur_req = "R1";

  function automatic logic [TAPS-1:0] ones(int n);
    if (n >= TAPS) return '1;
    if (n <= 0) return '0;
    return (TAPS'(1) << n) - TAPS'(1);
  endfunction

  function automatic logic [TAPS-1:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  function automatic logic [CW-1:0] tbl_init(int i);
    return CW'(i * 13 + 7);
  endfunction

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  task automatic step(bit sv, logic [TAPS-1:0] a, logic [TAPS-1:0] b,
                      bit we, logic [WW-1:0] addr, logic [CW-1:0] data);
    @(negedge clk);
    check("code_valid", 32'(code_valid), 32'(cv_m));
    check("code", 32'(code), 32'(code_m));
    snap_valid = sv; chain_a = a; chain_b = b;
    lut_we = we; lut_addr = addr; lut_wdata = data;
    if (v3) code_m = tbl_m[w3];
    cv_m = v3;
    if (v2) w3 = w2;
    v3 = v2;
    if (v1) w2 = w1;
    v2 = v1;
    if (sv) w1 = WW'($countones(a) + $countones(b));
    v1 = sv;
    if (we && int'(addr) < DEPTH) tbl_m[addr] = data;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step(1'b0, rnd128(), rnd128(), 1'b0, '0, '0);
  endtask

  task automatic snap_w(int w);
    step(1'b1, ones((w + 1) / 2), ones(w / 2), 1'b0, '0, '0);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    v1 = 0; v2 = 0; v3 = 0; cv_m = 0; w1 = '0; w2 = '0; w3 = '0; code_m = '0;

    // R1: reset state
    repeat (3) @(negedge clk);
    cur_req = "R1";
    check("reset code_valid", 32'(code_valid), 32'd0);
    check("reset code", 32'(code), 32'd0);
    rst_n = 1'b1;

    // R7: initial table load
    cur_req = "R7";
    for (int i = 0; i < DEPTH; i++) step(1'b0, '0, '0, 1'b1, WW'(i), tbl_init(i));

    // R2: random snapshots with gaps
    cur_req = "R2";
    for (int k = 0; k < 300; k++) begin
      logic [TAPS-1:0] a, b;
      a = rnd128(); b = rnd128();
      if (k % 3 == 1) begin a = a & rnd128(); b = b & rnd128(); end
      if (k % 3 == 2) begin a = a | rnd128(); b = b | rnd128(); end
      step(($urandom() % 4) != 0, a, b, 1'b0, '0, '0);
    end
    idle(4);

    // R3: high region wrapping both ends of the line
    cur_req = "R3";
    for (int j = 1; j < 60; j += 7) begin
      logic [TAPS-1:0] a, b;
      a = ones(j) | ~ones(TAPS - (j + 3));
      b = ones(j + 1) | ~ones(TAPS - (j + 2));
      step(1'b1, a, b, 1'b0, '0, '0);
    end
    idle(4);

    // R4: empty and full snapshots, back to back
    cur_req = "R4";
    step(1'b1, '0, '0, 1'b0, '0, '0);
    step(1'b1, '1, '1, 1'b0, '0, '0);
    step(1'b1, '1, '1, 1'b0, '0, '0);
    step(1'b1, '0, '0, 1'b0, '0, '0);
    idle(4);

    // R5: one code per snapshot on every clock
    cur_req = "R5";
    for (int k = 0; k < 100; k++) step(1'b1, rnd128(), rnd128(), 1'b0, '0, '0);
    idle(4);

    // R6: inputs ignored while not valid, code held
    cur_req = "R6";
    snap_w(77);
    idle(12);

    // R7: rewrite entries, then look them up
    cur_req = "R7";
    for (int i = 0; i < DEPTH; i += 3) step(1'b0, '0, '0, 1'b1, WW'(i), CW'($urandom()));
    for (int k = 0; k < 80; k++) snap_w(int'($urandom() % DEPTH));
    idle(4);

    // R8: out-of-range writes change nothing
    cur_req = "R8";
    step(1'b0, '0, '0, 1'b1, WW'(257), 12'hABC);
    step(1'b0, '0, '0, 1'b1, WW'(300), 12'hABD);
    step(1'b0, '0, '0, 1'b1, WW'(511), 12'hABE);
    snap_w(1); snap_w(44); snap_w(255); snap_w(256); snap_w(0);
    idle(4);

    // R9: write and lookup of the same entry on the same edge
    cur_req = "R9";
    snap_w(100);
    idle(2);
    step(1'b0, '0, '0, 1'b1, WW'(100), ~tbl_m[100]);
    idle(1);
    snap_w(100);
    idle(4);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule